// File: doc/BRIEF.md
# Register-Mapped Counter and Compare Timer Frame

This block is one 32-bit register frame that makes a free-running 64-bit system count visible to software, together with two compare timers. It shows the physical count, a virtual count (the physical count less a 64-bit virtual offset), the count frequency, the virtual offset, and a physical and a virtual compare timer. Every 64-bit quantity is split into a low and a high 32-bit word.

Access is gated at two levels. A 6-bit access field, supplied by a global control block outside this frame, decides which register groups may be touched at all. A second mask, held in the frame itself, narrows what a reduced-privilege requester may see. A single allow flag can close the whole frame. A request that is not permitted reads as zero and a write that is not permitted is dropped. No error is signalled in either case.

Each timer compares its count against a 64-bit compare value. It can also be programmed with a signed 32-bit delta relative to the current count, and it drives one interrupt line.

Top module: `tmr_frame`

## Requirements
- R1: The bus address is a 4-bit word index (byte offset divided by 4). Word 0/1 read the physical count low/high, word 4 reads the frequency input, and words 6/7 read the virtual offset low/high.
- R2: Words 2/3 read the low/high half of the virtual count, which is the physical count input minus the virtual offset input, modulo 2^64.
- R3: A permitted read of word 0 (or word 2) latches the high half of the physical (or virtual) count in the same cycle. A later read of word 1 (or word 3) returns that latched half, even if the count has moved on since.
- R4: The access field gates reads as follows. Bit 0 gates physical count. Bit 1 gates virtual count. Bit 2 gates frequency. Bit 3 gates virtual offset. Bit 5 gates read and write of the physical timer, words 8-11. Bit 4 gates read and write of the virtual timer, words 12-15. A read that is not permitted returns zero.
- R5: A timer write while that timer's access bit is clear leaves the compare value and control unchanged.
- R6: Word 5 holds the reduced-view mask, and only bits 0, 1, 8 and 9 are stored. With the reduced-privilege flag set, the following rules apply. Counts need mask bit 0 (physical) or bit 1 (virtual). Frequency needs either of those bits. The physical timer needs bit 9 and the virtual timer needs bit 8. Word 5 and the virtual offset read zero, and a write to word 5 is ignored.
- R7: With the frame-allow input low, every read returns zero and every write is ignored.
- R8: A timer control word has enable at bit 0, mask at bit 1 and status at bit 2 (read-only). Status is set when the timer is enabled and its count is at or above the compare value (unsigned). The interrupt is the status with the mask applied, registered one cycle.
- R9: Reading the timer-value word (8 or 12) returns the compare value minus the timer's count, truncated to 32 bits. Writing it sets the compare value to the timer's count plus the sign-extended data.
- R10: Writes to the count, frequency and offset words (0-4, 6, 7) change nothing.
- R11: Read data is registered. It appears in the cycle after the request and is zero after any cycle without a permitted read.
- R12: After reset, the compare values, control bits, reduced-view mask, latched high words, read data and interrupts are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Request valid |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Word index |
| busWdata | input | 32 | Write data |
| busLowPriv | input | 1 | Request comes from the reduced-privilege view |
| busRdata | output | 32 | Read data, one cycle after the request |
| frameAllow | input | 1 | Whole-frame access allow |
| accessBits | input | 6 | Per-group access field |
| countIn | input | 64 | Physical system count |
| freqIn | input | 32 | Count frequency value |
| voffIn | input | 64 | Virtual offset |
| irqPhys | output | 1 | Physical timer interrupt |
| irqVirt | output | 1 | Virtual timer interrupt |

## Verification
The results become visible at different times. A read result appears at the clock edge that follows the request. A write updates the timer state or the mask at the request edge itself. The interrupt follows the state with one extra register stage. The bench presents each request half a cycle before the edge and samples read data half a cycle after it. It computes the expected value from the model state as it stood before that edge, and only then applies the request's own effects to the model. Interrupt checks are taken after two idle cycles with the count held still, so that the new timer state and the registered interrupt stage have both settled.

// File: rtl/tmr_frame_pkg.sv
package tmr_frame_pkg;
  localparam int WORD_W  = 32;
  localparam int CNT_W   = 2 * WORD_W;
  localparam int SEL_W   = 4;
  localparam int ACC_W   = 6;
  localparam int LPM_W   = 10;
  localparam int NUM_TMR = 2;

  // access field bit positions
  localparam int ACC_PCNT = 0;
  localparam int ACC_VCNT = 1;
  localparam int ACC_FREQ = 2;
  localparam int ACC_VOFF = 3;
  localparam int ACC_VTMR = 4;
  localparam int ACC_PTMR = 5;

  // reduced-view mask bits that are stored
  localparam logic [LPM_W-1:0] LPM_KEEP = 10'h303;

  // word indices
  localparam logic [SEL_W-1:0] W_PCNT_LO = 4'h0;
  localparam logic [SEL_W-1:0] W_PCNT_HI = 4'h1;
  localparam logic [SEL_W-1:0] W_VCNT_LO = 4'h2;
  localparam logic [SEL_W-1:0] W_VCNT_HI = 4'h3;
  localparam logic [SEL_W-1:0] W_FREQ    = 4'h4;
  localparam logic [SEL_W-1:0] W_LPMASK  = 4'h5;
  localparam logic [SEL_W-1:0] W_VOFF_LO = 4'h6;
  localparam logic [SEL_W-1:0] W_VOFF_HI = 4'h7;

  typedef struct packed {
    logic             rdOk;
    logic             wrOk;
    logic [SEL_W-1:0] word;
  } frameStb_t;
endpackage

// File: rtl/tmr_frame_ctrl.sv
module tmr_frame_ctrl
  import tmr_frame_pkg::*;
(
  input  logic             busSel,
  input  logic             busWr,
  input  logic [SEL_W-1:0] busAddr,
  input  logic             busLowPriv,
  input  logic             frameAllow,
  input  logic [ACC_W-1:0] accessBits,
  input  logic [3:0]       lpGate,     // {tmrP, tmrV, cntV, cntP}
  output frameStb_t        stb
);
  logic rdPerm, wrPerm, tmrPerm;
  logic lpCntP, lpCntV, lpTmrV, lpTmrP;

  always_comb begin
    lpCntP = !busLowPriv || lpGate[0];
    lpCntV = !busLowPriv || lpGate[1];
    lpTmrV = !busLowPriv || lpGate[2];
    lpTmrP = !busLowPriv || lpGate[3];
    tmrPerm = busAddr[2] ? (accessBits[ACC_VTMR] && lpTmrV)
                         : (accessBits[ACC_PTMR] && lpTmrP);
    rdPerm = 1'b0;
    wrPerm = 1'b0;
    if (busAddr[3]) begin
      rdPerm = tmrPerm;
      wrPerm = tmrPerm;
    end else begin
      case (busAddr)
        W_PCNT_LO, W_PCNT_HI: rdPerm = accessBits[ACC_PCNT] && lpCntP;
        W_VCNT_LO, W_VCNT_HI: rdPerm = accessBits[ACC_VCNT] && lpCntV;
        W_FREQ:    rdPerm = accessBits[ACC_FREQ] &&
                            (!busLowPriv || lpGate[0] || lpGate[1]);
        W_LPMASK: begin
          rdPerm = !busLowPriv;
          wrPerm = !busLowPriv;
        end
        W_VOFF_LO, W_VOFF_HI: rdPerm = accessBits[ACC_VOFF] && !busLowPriv;
        default: rdPerm = 1'b0;
      endcase
    end
    stb.rdOk = busSel && !busWr && frameAllow && rdPerm;
    stb.wrOk = busSel &&  busWr && frameAllow && wrPerm;
    stb.word = busAddr;
  end
endmodule

// File: rtl/tmr_frame_cmp.sv
module tmr_frame_cmp
  import tmr_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wrLo,
  input  logic              wrHi,
  input  logic              wrTval,
  input  logic              wrCtl,
  input  logic [WORD_W-1:0] wdata,
  output logic [CNT_W-1:0]  cval,
  output logic [2:0]        ctl,
  output logic [WORD_W-1:0] tval,
  output logic              irq
);
  logic en, mask, status;

  always_comb begin
    status = en && (cnt >= cval);
    ctl    = {status, mask, en};
    tval   = cval[WORD_W-1:0] - cnt[WORD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cval <= '0;
      en   <= 1'b0;
      mask <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= status && !mask;
      if (wrLo)   cval[WORD_W-1:0]     <= wdata;
      if (wrHi)   cval[CNT_W-1:WORD_W] <= wdata;
      if (wrTval) cval <= cnt + {{(CNT_W-WORD_W){wdata[WORD_W-1]}}, wdata};
      if (wrCtl) begin
        en   <= wdata[0];
        mask <= wdata[1];
      end
    end
  end
endmodule

// File: rtl/tmr_frame_dp.sv
module tmr_frame_dp
  import tmr_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  frameStb_t         stb,
  input  logic [WORD_W-1:0] busWdata,
  input  logic [CNT_W-1:0]  countIn,
  input  logic [WORD_W-1:0] freqIn,
  input  logic [CNT_W-1:0]  voffIn,
  output logic [WORD_W-1:0] busRdata,
  output logic [3:0]        lpGate,
  output logic [2:0]        physCtl,
  output logic [2:0]        virtCtl,
  output logic              irqPhys,
  output logic              irqVirt
);
  logic [LPM_W-1:0]  lpMask;
  logic [WORD_W-1:0] snapP, snapV, rdVal;
  logic [CNT_W-1:0]  vcnt;
  logic [CNT_W-1:0]  cntA  [NUM_TMR];
  logic [CNT_W-1:0]  cvalA [NUM_TMR];
  logic [2:0]        ctlA  [NUM_TMR];
  logic [WORD_W-1:0] tvalA [NUM_TMR];
  logic              irqA  [NUM_TMR];

  assign vcnt    = countIn - voffIn;
  assign lpGate  = {lpMask[9], lpMask[8], lpMask[1], lpMask[0]};
  assign physCtl = ctlA[0];
  assign virtCtl = ctlA[1];
  assign irqPhys = irqA[0];
  assign irqVirt = irqA[1];

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    localparam logic SEL_HI = (t == 1);
    logic hit;
    assign cntA[t] = (t == 0) ? countIn : vcnt;
    assign hit = stb.wrOk && stb.word[3] && (stb.word[2] == SEL_HI);
    tmr_frame_cmp u_cmp (
      .clk    (clk),
      .rstN   (rstN),
      .cnt    (cntA[t]),
      .wrLo   (hit && stb.word[1:0] == 2'd0),
      .wrHi   (hit && stb.word[1:0] == 2'd1),
      .wrTval (hit && stb.word[1:0] == 2'd2),
      .wrCtl  (hit && stb.word[1:0] == 2'd3),
      .wdata  (busWdata),
      .cval   (cvalA[t]),
      .ctl    (ctlA[t]),
      .tval   (tvalA[t]),
      .irq    (irqA[t])
    );
  end

  always_comb begin
    rdVal = '0;
    if (stb.word[3]) begin
      case (stb.word[1:0])
        2'd0: rdVal = cvalA[stb.word[2]][WORD_W-1:0];
        2'd1: rdVal = cvalA[stb.word[2]][CNT_W-1:WORD_W];
        2'd2: rdVal = tvalA[stb.word[2]];
        default: rdVal = {{(WORD_W-3){1'b0}}, ctlA[stb.word[2]]};
      endcase
    end else begin
      case (stb.word)
        W_PCNT_LO: rdVal = countIn[WORD_W-1:0];
        W_PCNT_HI: rdVal = snapP;
        W_VCNT_LO: rdVal = vcnt[WORD_W-1:0];
        W_VCNT_HI: rdVal = snapV;
        W_FREQ:    rdVal = freqIn;
        W_LPMASK:  rdVal = {{(WORD_W-LPM_W){1'b0}}, lpMask};
        W_VOFF_LO: rdVal = voffIn[WORD_W-1:0];
        default:   rdVal = voffIn[CNT_W-1:WORD_W];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
      snapP    <= '0;
      snapV    <= '0;
      lpMask   <= '0;
    end else begin
      busRdata <= stb.rdOk ? rdVal : '0;
      if (stb.rdOk && stb.word == W_PCNT_LO) snapP <= countIn[CNT_W-1:WORD_W];
      if (stb.rdOk && stb.word == W_VCNT_LO) snapV <= vcnt[CNT_W-1:WORD_W];
      if (stb.wrOk && stb.word == W_LPMASK)  lpMask <= busWdata[LPM_W-1:0] & LPM_KEEP;
    end
  end
endmodule

// File: rtl/tmr_frame.sv
module tmr_frame
  import tmr_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [SEL_W-1:0]  busAddr,
  input  logic [WORD_W-1:0] busWdata,
  input  logic              busLowPriv,
  output logic [WORD_W-1:0] busRdata,
  input  logic              frameAllow,
  input  logic [ACC_W-1:0]  accessBits,
  input  logic [CNT_W-1:0]  countIn,
  input  logic [WORD_W-1:0] freqIn,
  input  logic [CNT_W-1:0]  voffIn,
  output logic              irqPhys,
  output logic              irqVirt
);
  frameStb_t  stb;
  logic [3:0] lpGate;
  logic [2:0] physCtlW, virtCtlW;

  tmr_frame_ctrl u_ctrl (
    .busSel     (busSel),
    .busWr      (busWr),
    .busAddr    (busAddr),
    .busLowPriv (busLowPriv),
    .frameAllow (frameAllow),
    .accessBits (accessBits),
    .lpGate     (lpGate),
    .stb        (stb)
  );

  tmr_frame_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busWdata (busWdata),
    .countIn  (countIn),
    .freqIn   (freqIn),
    .voffIn   (voffIn),
    .busRdata (busRdata),
    .lpGate   (lpGate),
    .physCtl  (physCtlW),
    .virtCtl  (virtCtlW),
    .irqPhys  (irqPhys),
    .irqVirt  (irqVirt)
  );
endmodule

// File: rtl/tmr_frame_chk.sv
module tmr_frame_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busSel,
  input logic        busWr,
  input logic [3:0]  busAddr,
  input logic        busLowPriv,
  input logic        frameAllow,
  input logic [31:0] busRdata,
  input logic        irqPhys,
  input logic        irqVirt,
  input logic [2:0]  physCtl,
  input logic [2:0]  virtCtl
);
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWr) |=> busRdata == 32'd0);

  a_r7_closed_frame: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !frameAllow) |=> busRdata == 32'd0);

  a_r6_lowpriv_voff: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busLowPriv && busAddr[3:1] == 3'b011) |=> busRdata == 32'd0);

  a_r8_phys_irq_gate: assert property (@(posedge clk) disable iff (!rstN)
    irqPhys |-> $past(physCtl[0] && !physCtl[1] && physCtl[2]));

  a_r8_virt_irq_gate: assert property (@(posedge clk) disable iff (!rstN)
    irqVirt |-> $past(virtCtl[0] && !virtCtl[1] && virtCtl[2]));
endmodule

bind tmr_frame tmr_frame_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busSel     (busSel),
  .busWr      (busWr),
  .busAddr    (busAddr),
  .busLowPriv (busLowPriv),
  .frameAllow (frameAllow),
  .busRdata   (busRdata),
  .irqPhys    (irqPhys),
  .irqVirt    (irqVirt),
  .physCtl    (physCtlW),
  .virtCtl    (virtCtlW)
);

// File: tb/tmr_frame_bench.sv
module tmr_frame_bench;
  logic        clk = 1'b0;
  logic        rstN, busSel, busWr, busLowPriv, frameAllow;
  logic [3:0]  busAddr;
  logic [31:0] busWdata, busRdata, freqIn;
  logic [5:0]  accessBits;
  logic [63:0] countIn, voffIn;
  logic        irqPhys, irqVirt;

  int nChk = 0, nFail = 0;
  bit done = 0;

  logic [63:0] mCval [2];
  logic [1:0]  mCtl  [2];
  logic [9:0]  mLp;
  logic [31:0] mSnap [2];

  always #2 clk = ~clk;

  tmr_frame u_tmr_frame (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busLowPriv(busLowPriv), .busRdata(busRdata),
    .frameAllow(frameAllow), .accessBits(accessBits), .countIn(countIn),
    .freqIn(freqIn), .voffIn(voffIn), .irqPhys(irqPhys), .irqVirt(irqVirt)
  );

  function automatic logic [63:0] tmrCnt(int t);
    return (t == 0) ? countIn : countIn - voffIn;
  endfunction

  function automatic bit permOk(logic [3:0] w, bit isWr);
    bit lp = busLowPriv;
    bit p;
    if (!frameAllow) return 0;
    if (w[3]) begin
      if (w[2]) p = accessBits[4] && (!lp || mLp[8]);
      else      p = accessBits[5] && (!lp || mLp[9]);
      return p;
    end
    if (w == 4'd5) return !lp;
    if (isWr) return 0;
    case (w)
      4'd0, 4'd1: p = accessBits[0] && (!lp || mLp[0]);
      4'd2, 4'd3: p = accessBits[1] && (!lp || mLp[1]);
      4'd4:       p = accessBits[2] && (!lp || mLp[0] || mLp[1]);
      default:    p = accessBits[3] && !lp;
    endcase
    return p;
  endfunction

  function automatic logic [31:0] expRead(logic [3:0] w);
    logic [63:0] c;
    int t;
    bit st;
    if (!permOk(w, 0)) return 32'd0;
    if (w[3]) begin
      t = w[2] ? 1 : 0;
      c = tmrCnt(t);
      st = mCtl[t][0] && (c >= mCval[t]);
      case (w[1:0])
        2'd0: return mCval[t][31:0];
        2'd1: return mCval[t][63:32];
        2'd2: return mCval[t][31:0] - c[31:0];
        default: return {29'd0, st, mCtl[t]};
      endcase
    end
    c = tmrCnt(1);
    case (w)
      4'd0: return countIn[31:0];
      4'd1: return mSnap[0];
      4'd2: return c[31:0];
      4'd3: return mSnap[1];
      4'd4: return freqIn;
      4'd5: return {22'd0, mLp};
      4'd6: return voffIn[31:0];
      default: return voffIn[63:32];
    endcase
  endfunction

  function automatic bit expIrq(int t);
    return mCtl[t][0] && !mCtl[t][1] && (tmrCnt(t) >= mCval[t]);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [3:0] w, string req);
    logic [31:0] e;
    logic [63:0] vc;
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = w;
    e = expRead(w);
    vc = tmrCnt(1);
    if (permOk(w, 0) && w == 4'd0) mSnap[0] = countIn[63:32];
    if (permOk(w, 0) && w == 4'd2) mSnap[1] = vc[63:32];
    @(negedge clk);
    busSel = 0;
    check(req, busRdata, e);
  endtask

  task automatic wr(logic [3:0] w, logic [31:0] d);
    int t;
    logic [63:0] c;
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = w; busWdata = d;
    if (permOk(w, 1)) begin
      if (w == 4'd5) mLp = d[9:0] & 10'h303;
      else if (w[3]) begin
        t = w[2] ? 1 : 0;
        c = tmrCnt(t);
        case (w[1:0])
          2'd0: mCval[t][31:0] = d;
          2'd1: mCval[t][63:32] = d;
          2'd2: mCval[t] = c + {{32{d[31]}}, d};
          default: mCtl[t] = d[1:0];
        endcase
      end
    end
    @(negedge clk);
    busSel = 0; busWr = 0;
    check("R11 no data after write", busRdata, 32'd0);
  endtask

  task automatic irqChk(string req);
    repeat (2) @(negedge clk);
    check(req, {31'd0, irqPhys}, {31'd0, expIrq(0)});
    check(req, {31'd0, irqVirt}, {31'd0, expIrq(1)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 0; busSel = 0; busWr = 0; busAddr = 0; busWdata = 0; busLowPriv = 0;
    frameAllow = 1; accessBits = 6'h3F; countIn = 64'h0000_0001_0000_0100;
    freqIn = 32'd50_000_000; voffIn = 64'h0000_0000_0000_0040;
    for (int t = 0; t < 2; t++) begin mCval[t] = 0; mCtl[t] = 0; mSnap[t] = 0; end
    mLp = 0;
    repeat (3) @(negedge clk);
    check("R12 reset rdata", busRdata, 32'd0);
    check("R12 reset irqPhys", {31'd0, irqPhys}, 32'd0);
    check("R12 reset irqVirt", {31'd0, irqVirt}, 32'd0);
    rstN = 1;
    rd(4'd5, "R12 mask reset");
    rd(4'd9, "R12 compare reset");
    rd(4'd15, "R12 control reset");
    rd(4'd1, "R12 snapshot reset");

    // R1/R2 map
    countIn = 64'h1234_5678_9ABC_DEF0; voffIn = 64'h0000_0001_0000_0001;
    rd(4'd0, "R1 pcount lo"); rd(4'd1, "R1 pcount hi");
    rd(4'd4, "R1 freq"); rd(4'd6, "R1 voff lo"); rd(4'd7, "R1 voff hi");
    rd(4'd2, "R2 vcount lo"); rd(4'd3, "R2 vcount hi");

    // R3 snapshot
    rd(4'd0, "R3 low read");
    countIn = 64'hAAAA_0000_0000_0000;
    rd(4'd1, "R3 latched high");
    rd(4'd2, "R3 virt low");
    countIn = 64'h5555_0000_0000_0000;
    rd(4'd3, "R3 virt latched high");

    // R4 gating
    accessBits = 6'h00;
    for (int w = 0; w < 16; w++) if (w != 5) rd(w[3:0], "R4 closed group");
    accessBits = 6'h3F;

    // R5 denied timer write
    accessBits = 6'h1F;
    wr(4'd8, 32'hDEAD_BEEF); wr(4'd11, 32'h1);
    accessBits = 6'h3F;
    rd(4'd8, "R5 cval unchanged"); rd(4'd11, "R5 ctl unchanged");
    accessBits = 6'h2F;
    wr(4'd12, 32'h1234); accessBits = 6'h3F;
    rd(4'd12, "R5 virt cval unchanged");

    // R6 reduced view
    busLowPriv = 1;
    rd(4'd0, "R6 lp pcount"); rd(4'd4, "R6 lp freq"); rd(4'd8, "R6 lp ptimer");
    wr(4'd5, 32'hFFFF_FFFF);
    busLowPriv = 0;
    rd(4'd5, "R6 lp write ignored");
    wr(4'd5, 32'hFFFF_FFFF);
    rd(4'd5, "R6 mask stored bits");
    busLowPriv = 1;
    rd(4'd0, "R6 lp pcount open"); rd(4'd2, "R6 lp vcount open");
    rd(4'd4, "R6 lp freq open"); rd(4'd6, "R6 lp voff"); rd(4'd5, "R6 lp mask read");
    rd(4'd11, "R6 lp ptimer open");
    busLowPriv = 0;
    wr(4'd5, 32'h0000_0002);
    busLowPriv = 1;
    rd(4'd4, "R6 lp freq via vcount bit"); rd(4'd0, "R6 lp pcount closed");
    busLowPriv = 0;

    // R7 frame closed
    frameAllow = 0;
    rd(4'd4, "R7 closed read"); wr(4'd5, 32'h303);
    frameAllow = 1;
    rd(4'd5, "R7 closed write ignored");

    // R8 compare and interrupts
    countIn = 64'h0000_0002_0000_0000;
    wr(4'd9, 32'h2); wr(4'd8, 32'h10); wr(4'd11, 32'h1);
    irqChk("R8 below compare");
    rd(4'd11, "R8 status low");
    countIn = 64'h0000_0002_0000_0010;
    irqChk("R8 at compare");
    rd(4'd11, "R8 status high");
    wr(4'd11, 32'h3);
    irqChk("R8 masked");
    rd(4'd11, "R8 status masked");
    voffIn = 64'h0000_0000_0000_0100;
    wr(4'd13, 32'h2); wr(4'd12, 32'h0); wr(4'd15, 32'h1);
    irqChk("R8 virt below");
    countIn = 64'h0000_0002_0000_0100;
    irqChk("R8 virt at compare");

    // R9 timer value
    wr(4'd10, 32'hFFFF_FFFD);
    rd(4'd10, "R9 tval negative"); rd(4'd8, "R9 cval lo"); rd(4'd9, "R9 cval hi");
    wr(4'd14, 32'h0000_0100);
    rd(4'd14, "R9 virt tval"); rd(4'd12, "R9 virt cval");
    irqChk("R9 irq after tval");

    // R10 read-only words
    for (int w = 0; w < 8; w++) if (w != 5) wr(w[3:0], 32'hFFFF_FFFF);
    rd(4'd4, "R10 freq"); rd(4'd6, "R10 voff lo"); rd(4'd0, "R10 pcount");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] w;
      logic [31:0] d;
      w = 4'($urandom_range(0, 15));
      accessBits = 6'($urandom);
      if ($urandom_range(0, 3) == 0) accessBits = 6'h3F;
      busLowPriv = 1'($urandom_range(0, 2) == 0);
      frameAllow = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 3) == 0)
        countIn = {32'($urandom_range(1, 3)), $urandom};
      d = (w[1:0] == 2'd1) ? 32'($urandom_range(1, 3)) : $urandom;
      if ($urandom_range(0, 1) == 1) wr(w, d);
      else rd(w, "R4 R6 random read");
      if (i % 8 == 0) irqChk("R8 random irq");
    end

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule